// File: doc/BRIEF.md
# Posted Store Buffer with Line Eviction Slot

This block sits between a processor's store port and a slower external memory bus. The core hands it one word per cycle and moves on. The block holds each store and later replays it on the memory side at whatever pace the bus grants. Word data lives in a shared 16-entry store. Addresses live in a smaller 4-entry store, and each address entry heads a run of consecutive words. A store that continues the newest run joins that run and takes no new address slot.

A separate one-line slot takes whole dirty cache lines (8 words under one line address) on eviction or cleaning. When both sources hold data, the line slot wins at burst boundaries. A burst that has already started on the bus is never broken up. The `drained` output goes high only when nothing is held anywhere. Software can treat it as a write barrier.

All addresses are word addresses, so the next word's address is the previous one plus 1.

Top module: `store_post_buffer`

## Requirements
- R1: Right after reset, `core_ready` and `evict_ready` are 1, `mem_req` is 0 and `drained` is 1.
- R2: `core_ready` is 0 exactly when 16 words are held or 4 address entries are in use, even if the next store could have joined a run. Otherwise it is 1, and a store with `core_valid` high is taken on that edge.
- R3: Held words leave on the memory side in arrival order, each carrying the address it was stored at. `mem_last` is 1 on the final word of each address entry and 0 on the others.
- R4: A store whose address equals the start plus the length of the newest entry is added to that entry. It takes no new address slot, so it adds no extra `mem_last` mark.
- R5: A store never joins the entry at the head of the queue while that entry is the one presented on the memory side. With only one entry in use and the queue selected, a consecutive store opens a second entry.
- R6: A line load is taken when `evict_valid` and `evict_ready` are both 1. `evict_ready` then stays 0 until the line has left. The line leaves as 8 words at `evict_addr`+0 through +7, with word j taken from bits [32*j+31:32*j] of `evict_line`, and `mem_last` is set on the eighth word.
- R7: When the line slot is full and the queue is not in the middle of an entry, the line goes out first. A queue entry that has already started finishes before the line begins.
- R8: While `mem_req` is 1 and `mem_ready` is 0, `mem_req`, `mem_addr`, `mem_data` and `mem_last` do not change on the next cycle.
- R9: `drained` is 1 exactly when both stores are empty. While it is 1, `mem_req` is 0.
- R10: Stores keep being taken while the memory side is stalled, up to the limits in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_valid | input | 1 | Store offered by the core |
| core_addr | input | AW | Word address of the store |
| core_data | input | DW | Store data |
| core_ready | output | 1 | Store can be taken this cycle |
| evict_valid | input | 1 | Dirty line offered |
| evict_addr | input | AW | Word address of the line's first word |
| evict_line | input | LINE*DW | Line data, word 0 in the low bits |
| evict_ready | output | 1 | Line slot is empty |
| mem_req | output | 1 | Word presented to memory |
| mem_addr | output | AW | Word address presented |
| mem_data | output | DW | Word data presented |
| mem_last | output | 1 | Final word of the current burst |
| mem_ready | input | 1 | Memory takes the presented word on this edge |
| drained | output | 1 | Nothing held in either store |

## Verification
Suppose the joining decision, the entry length or the head offset is wrong. Then the `mem_last` marks land on the wrong words, or a word repeats or is skipped, on the very word where the drain reaches the damaged entry. Occupancy faults show up at once on `core_ready` within the store sweep that fills the buffer, because the bench predicts when each limit is reached. A wrong source choice shows up as a line word appearing in place of an expected queue word in the replayed stream. The memory side is stalled during the fills and paced irregularly during drains, so hold and ordering faults appear in the same cycle they occur.

// File: rtl/spb_pkg.sv
package spb_pkg;
    typedef enum logic {
        SRC_QUEUE = 1'b0,
        SRC_EVICT = 1'b1
    } src_e;

    typedef struct packed {
        logic stall;
        src_e src;
    } arb_t;
endpackage

// File: rtl/spb_post_queue.sv
module spb_post_queue #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int AENT  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    output logic          push_ready,
    input  logic          head_granted,
    input  logic          pop,
    output logic          head_valid,
    output logic          head_started,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          head_last
);
    localparam int DPW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int EPW = (AENT > 1) ? $clog2(AENT) : 1;
    localparam int ECW = $clog2(AENT + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] data;
        logic [AENT-1:0][AW-1:0]  eaddr;
        logic [AENT-1:0][CW-1:0]  elen;
        logic [DPW-1:0]           wp;
        logic [DPW-1:0]           rp;
        logic [DPW-1:0]           hoff;
        logic [EPW-1:0]           ewp;
        logic [EPW-1:0]           erp;
        logic [CW-1:0]            dcnt;
        logic [ECW-1:0]           ecnt;
    } qstate_t;

    qstate_t st_d, st_q;
    logic [EPW-1:0] tail;
    logic [AW-1:0]  tail_end;
    logic           acc, merge, take;

    function automatic logic [DPW-1:0] dinc(input logic [DPW-1:0] p);
        return (p == DPW'(DEPTH - 1)) ? '0 : p + DPW'(1);
    endfunction

    function automatic logic [EPW-1:0] einc(input logic [EPW-1:0] p);
        return (p == EPW'(AENT - 1)) ? '0 : p + EPW'(1);
    endfunction

    always_comb begin
        st_d         = st_q;
        tail         = (st_q.ewp == '0) ? EPW'(AENT - 1) : st_q.ewp - EPW'(1);
        tail_end     = st_q.eaddr[tail] + AW'(st_q.elen[tail]);
        push_ready   = (st_q.dcnt != CW'(DEPTH)) && (st_q.ecnt != ECW'(AENT));
        head_valid   = (st_q.ecnt != '0);
        head_started = (st_q.hoff != '0);
        head_addr    = st_q.eaddr[st_q.erp] + AW'(st_q.hoff);
        head_data    = st_q.data[st_q.rp];
        head_last    = ((CW'(st_q.hoff) + CW'(1)) == st_q.elen[st_q.erp]);
        acc          = push_valid && push_ready;
        take         = pop && head_valid;
        // the newest entry may grow unless it is the one on the bus
        merge        = (st_q.ecnt != '0) && (push_addr == tail_end)
                       && !((st_q.ecnt == ECW'(1)) && head_granted);

        if (take) begin
            st_d.rp = dinc(st_q.rp);
            if (head_last) begin
                st_d.erp  = einc(st_q.erp);
                st_d.hoff = '0;
            end else begin
                st_d.hoff = st_q.hoff + DPW'(1);
            end
        end

        if (acc) begin
            st_d.data[st_q.wp] = push_data;
            st_d.wp            = dinc(st_q.wp);
            if (merge) begin
                st_d.elen[tail] = st_q.elen[tail] + CW'(1);
            end else begin
                st_d.eaddr[st_q.ewp] = push_addr;
                st_d.elen[st_q.ewp]  = CW'(1);
                st_d.ewp             = einc(st_q.ewp);
            end
        end

        st_d.dcnt = st_q.dcnt + CW'(acc) - CW'(take);
        st_d.ecnt = st_q.ecnt + ECW'(acc && !merge) - ECW'(take && head_last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spb_evict_line.sv
module spb_evict_line #(
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int LINE = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_valid,
    input  logic [AW-1:0]      load_addr,
    input  logic [LINE*DW-1:0] load_data,
    output logic               load_ready,
    input  logic               pop,
    output logic               head_valid,
    output logic [AW-1:0]      head_addr,
    output logic [DW-1:0]      head_data,
    output logic               head_last
);
    localparam int LPW = (LINE > 1) ? $clog2(LINE) : 1;

    typedef struct packed {
        logic                     full;
        logic [AW-1:0]            base;
        logic [LINE-1:0][DW-1:0]  words;
        logic [LPW-1:0]           off;
    } estate_t;

    estate_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        load_ready = !st_q.full;
        head_valid = st_q.full;
        head_addr  = st_q.base + AW'(st_q.off);
        head_data  = st_q.words[st_q.off];
        head_last  = (st_q.off == LPW'(LINE - 1));

        if (pop && st_q.full) begin
            if (head_last) begin
                st_d.full = 1'b0;
                st_d.off  = '0;
            end else begin
                st_d.off = st_q.off + LPW'(1);
            end
        end else if (load_valid && !st_q.full) begin
            st_d.full  = 1'b1;
            st_d.base  = load_addr;
            st_d.words = load_data;
            st_d.off   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/store_post_buffer.sv
module store_post_buffer
    import spb_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int AENT  = 4,
    parameter int LINE  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               core_valid,
    input  logic [AW-1:0]      core_addr,
    input  logic [DW-1:0]      core_data,
    output logic               core_ready,
    input  logic               evict_valid,
    input  logic [AW-1:0]      evict_addr,
    input  logic [LINE*DW-1:0] evict_line,
    output logic               evict_ready,
    output logic               mem_req,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_data,
    output logic               mem_last,
    input  logic               mem_ready,
    output logic               drained
);
    logic          q_valid, q_started, q_last, q_pop, q_granted;
    logic [AW-1:0] q_addr;
    logic [DW-1:0] q_data;
    logic          e_valid, e_last, e_pop;
    logic [AW-1:0] e_addr;
    logic [DW-1:0] e_data;
    logic          sel_is_evict;
    src_e          sel;
    arb_t          arb_d, arb_q;

    spb_post_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .AENT(AENT)) queue_i (
        .clk(clk), .rst_n(rst_n),
        .push_valid(core_valid), .push_addr(core_addr), .push_data(core_data),
        .push_ready(core_ready), .head_granted(q_granted), .pop(q_pop),
        .head_valid(q_valid), .head_started(q_started), .head_addr(q_addr),
        .head_data(q_data), .head_last(q_last)
    );

    spb_evict_line #(.AW(AW), .DW(DW), .LINE(LINE)) line_i (
        .clk(clk), .rst_n(rst_n),
        .load_valid(evict_valid), .load_addr(evict_addr), .load_data(evict_line),
        .load_ready(evict_ready), .pop(e_pop),
        .head_valid(e_valid), .head_addr(e_addr), .head_data(e_data), .head_last(e_last)
    );

    always_comb begin
        // a stalled word keeps its source; otherwise the line wins between bursts
        if (arb_q.stall)                 sel = arb_q.src;
        else if (e_valid && !q_started)  sel = SRC_EVICT;
        else                             sel = SRC_QUEUE;

        sel_is_evict = (sel == SRC_EVICT);
        q_granted    = !sel_is_evict;
        mem_req      = sel_is_evict ? e_valid : q_valid;
        mem_addr     = sel_is_evict ? e_addr  : q_addr;
        mem_data     = sel_is_evict ? e_data  : q_data;
        mem_last     = sel_is_evict ? e_last  : q_last;
        e_pop        = mem_req && mem_ready && sel_is_evict;
        q_pop        = mem_req && mem_ready && !sel_is_evict;
        drained      = !q_valid && !e_valid;
        arb_d.stall  = mem_req && !mem_ready;
        arb_d.src    = sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arb_q <= '{stall: 1'b0, src: SRC_QUEUE};
        else        arb_q <= arb_d;
    end
endmodule

// File: rtl/spb_checker.sv
module spb_checker #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          core_valid,
    input logic          core_ready,
    input logic          evict_valid,
    input logic          evict_ready,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_data,
    input logic          mem_last,
    input logic          mem_ready,
    input logic          drained,
    input logic          sel_is_evict
);
    localparam int OW = $clog2(DEPTH + 1) + 1;
    logic [OW-1:0] held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held <= '0;
        else held <= held + OW'(core_valid && core_ready)
                          - OW'(mem_req && mem_ready && !sel_is_evict);
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        held <= OW'(DEPTH));
    assert_full_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (held == OW'(DEPTH)) |-> !core_ready);
    assert_burst_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_last) |=>
            (mem_req && (mem_addr == $past(mem_addr) + AW'(1))));
    assert_line_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && evict_ready) |=> !evict_ready);
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_data) && $stable(mem_last)));
    assert_drained_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drained |-> !mem_req);
endmodule

bind store_post_buffer spb_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .core_valid(core_valid), .core_ready(core_ready),
    .evict_valid(evict_valid), .evict_ready(evict_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_last(mem_last), .mem_ready(mem_ready), .drained(drained),
    .sel_is_evict(sel_is_evict)
);

// File: tb/store_post_buffer_tb_top.sv
module store_post_buffer_tb_top;
    localparam int AW = 16, DW = 32, DEPTH = 16, AENT = 4, LINE = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_valid = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic [DW-1:0] core_data = '0;
    logic core_ready;
    logic evict_valid = 1'b0;
    logic [AW-1:0] evict_addr = '0;
    logic [LINE*DW-1:0] evict_line = '0;
    logic evict_ready;
    logic mem_req, mem_last, drained;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic mem_ready = 1'b0;

    int total = 0;
    int bad = 0;

    logic [AW-1:0] ea [0:63];
    logic [DW-1:0] ed [0:63];
    logic          el [0:63];
    int            en;
    logic [AW-1:0] sa [0:20];
    logic [DW-1:0] sd [0:20];
    logic          sn [0:20];

    always #10 clk = ~clk;

    store_post_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .AENT(AENT), .LINE(LINE)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .core_valid(core_valid), .core_addr(core_addr), .core_data(core_data),
        .core_ready(core_ready),
        .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_line(evict_line),
        .evict_ready(evict_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_last(mem_last), .mem_ready(mem_ready), .drained(drained)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] pat_addr(input int p, input int sc, input int k);
        int run;
        case (p)
            0: run = 100;
            1: run = 1;
            2: run = 3;
            3: run = 2;
            4: run = 5;
            default: run = 7;
        endcase
        return AW'(32'h1000 + sc * 64 + k + 5 * (k / run));
    endfunction

    task automatic load_line(input int sc, input logic [AW-1:0] b);
        @(negedge clk);
        evict_valid = 1'b1;
        evict_addr  = b;
        for (int j = 0; j < LINE; j++) evict_line[j*DW +: DW] = 32'hE000_0000 + sc * 16 + j;
        #1;
        chk(evict_ready == 1'b1, "R6 slot free before load", evict_ready, 1);
        @(posedge clk);
        #1;
        evict_valid = 1'b0;
        @(negedge clk);
        #1;
        chk(evict_ready == 1'b0, "R6 slot busy while holding", evict_ready, 0);
    endtask

    task automatic add_line(input int sc, input logic [AW-1:0] b);
        for (int j = 0; j < LINE; j++) begin
            ea[en] = b + AW'(j);
            ed[en] = 32'hE000_0000 + sc * 16 + j;
            el[en] = (j == LINE - 1);
            en++;
        end
    endtask

    task automatic run_sc(input int sc);
        int p, evm, rm, nacc, ecnt, h, idx, guard;
        logic [AW-1:0] tend, addr, eb;
        bit granted, mr, merge, ok;
        p = sc % 6; evm = (sc / 6) % 3; rm = sc / 18;
        granted = (evm != 1);
        eb = AW'(32'h8000 + sc * 16);
        mem_ready = 1'b0; nacc = 0; ecnt = 0; tend = '0;
        if (evm == 1) load_line(sc, eb);
        for (int k = 0; k < 20; k++) begin
            addr = pat_addr(p, sc, k);
            mr = (nacc < DEPTH) && (ecnt < AENT);
            @(negedge clk);
            core_valid = 1'b1; core_addr = addr;
            core_data = 32'hA000_0000 + sc * 256 + k;
            #1;
            // R10: the bus is stalled throughout this fill
            chk(core_ready == mr, "R2 R10 core_ready vs occupancy", core_ready, mr);
            if (!mr) begin
                core_valid = 1'b0;
                break;
            end
            // R4 joining rule, R5 no joining into the presented head
            merge = (ecnt > 0) && (addr == tend) && (ecnt > 1 || !granted);
            sn[nacc] = !merge; sa[nacc] = addr; sd[nacc] = core_data;
            if (merge) tend = tend + AW'(1);
            else begin
                ecnt++;
                tend = addr + AW'(1);
            end
            nacc++;
            @(posedge clk);
            #1;
            core_valid = 1'b0;
        end
        @(negedge clk);
        #1;
        chk(drained == 1'b0, "R9 drained low while holding", drained, 0);
        if (evm == 2) load_line(sc, eb);

        en = 0; sn[nacc] = 1'b1;
        h = 1;
        while (h < nacc && !sn[h]) h++;
        if (evm == 1) add_line(sc, eb);              // R7 line first
        for (int i = 0; i < nacc; i++) begin
            if (evm == 2 && i == h) add_line(sc, eb); // R7 started entry finishes first
            ea[en] = sa[i]; ed[en] = sd[i]; el[en] = sn[i + 1]; en++;
        end
        if (evm == 2 && h >= nacc) add_line(sc, eb);

        idx = 0; guard = 0;
        while (idx < en && guard < 400) begin
            @(negedge clk);
            mem_ready = (rm == 0) ? 1'b1 : ((guard % 3) != 1);
            #1;
            if (mem_req) begin
                ok = (mem_addr == ea[idx]) && (mem_data == ed[idx]) && (mem_last == el[idx]);
                chk(ok, "R3 R4 R5 R6 R7 R8 word order/address/last",
                    {mem_last, 15'd0, mem_addr, mem_data},
                    {el[idx], 15'd0, ea[idx], ed[idx]});
                if (mem_ready) idx++;
            end else begin
                chk(1'b0, "R9 request dropped with words pending", 0, 1);
            end
            if (idx < en) chk(drained == 1'b0, "R9 drained while pending", drained, 0);
            guard++;
        end
        chk(idx == en, "R3 stream length", idx, en);
        @(negedge clk);
        mem_ready = 1'b0;
        #1;
        chk(drained == 1'b1 && mem_req == 1'b0, "R9 drained after stream",
            {drained, mem_req}, 2'b10);
        chk(core_ready == 1'b1 && evict_ready == 1'b1, "R2 R6 space back after drain",
            {core_ready, evict_ready}, 2'b11);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(mem_req == 1'b0, "R1 no request in reset", mem_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(core_ready == 1'b1, "R1 core_ready after reset", core_ready, 1);
        chk(evict_ready == 1'b1, "R1 evict_ready after reset", evict_ready, 1);
        chk(mem_req == 1'b0, "R1 mem_req after reset", mem_req, 0);
        chk(drained == 1'b1, "R1 drained after reset", drained, 1);
        for (int sc = 0; sc < 36; sc++) run_sc(sc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule